// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit for a multicycle processor datapath. The datapath has a single memory for instructions and data, an ALU that it reuses, and internal holding registers. The block steps each instruction through up to five phases: fetch, decode, execute, memory, and write-back. For each phase it drives the select and enable lines of the datapath. Its only data input is the opcode field of the instruction register.

Loads take five cycles. Stores and register-to-register ALU operations take four. Conditional branches on equality and jumps take three. An opcode that the block does not recognise spends one decode cycle and then goes back to fetch, with no write enable raised. The datapath computes the PC write enable from the two PC controls as `pc_wr | (pc_wr_cond & zero)`.

Every control output comes from a flop. The block decodes the next step and registers the result, so the outputs always match the step reported on `phase`.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high, every clock edge loads the fetch step with its fetch controls. The first cycle after `rst` falls is a fetch cycle.
- R2: Fetch step (`phase`=0) drives `mem_rd`=1, `iord`=0, `ir_wr`=1, `pc_wr`=1, `alu_src_a`=0 (PC), `alu_src_b`=1 (constant 4), `alu_op`=0 (add) and `pc_src`=0 (ALU result). In every step, any control not listed for that step is 0.
- R3: Decode (`phase`=1) always follows fetch. It drives `alu_src_a`=0, `alu_src_b`=3 (offset shifted left by 2) and `alu_op`=0, so the branch target lands in the ALU output register.
- R4: Opcode 6'b100011 (load) runs five steps. The execute step has `alu_src_a`=1 (register A), `alu_src_b`=2 (offset) and `alu_op`=0. The memory step (`phase`=3) has `mem_rd`=1 and `iord`=1. The write-back step (`phase`=4) has `reg_wr`=1, `mem_to_reg`=1 and `reg_dst`=0. It then returns to fetch.
- R5: Opcode 6'b101011 (store) uses the same execute step as a load. The memory step then has `mem_wr`=1 and `iord`=1, and the next step is fetch.
- R6: Opcode 6'b000000 (register ALU) executes with `alu_src_a`=1, `alu_src_b`=0 (register B) and `alu_op`=2 (use funct). The memory step has `reg_wr`=1 and `reg_dst`=1. It then returns to fetch.
- R7: Opcode 6'b000100 (branch on equal) executes with `alu_src_a`=1, `alu_src_b`=0, `alu_op`=1 (subtract), `pc_wr_cond`=1 and `pc_src`=1 (ALU output register). It then returns to fetch.
- R8: Opcode 6'b000010 (jump) executes with `pc_wr`=1 and `pc_src`=2 (jump target). It then returns to fetch.
- R9: Any other opcode goes from decode straight back to fetch. No step for it raises `pc_wr`, `pc_wr_cond`, `mem_wr`, `reg_wr` or `ir_wr`.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.
- R11: The block samples `opcode` only on the edge that ends decode. Changes to `opcode` in any other step have no effect on the step sequence or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data: 0 ALU output register, 1 memory data register |
| reg_dst | output | 1 | Destination register field: 0 rt, 1 rd |
| reg_wr | output | 1 | Register file write |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU operand B: 0 register B, 1 four, 2 offset, 3 offset shifted by 2 |
| alu_op | output | 2 | 0 add, 1 subtract, 2 use funct |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALU output register, 2 jump target |
| phase | output | 3 | Current step: 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back |

## Verification
The assertions check the following on every cycle:
- A memory read and a memory write never occur together.
- The instruction register loads only in fetch.
- Decode always follows fetch.
- A register-file write happens only in the memory or write-back step.
- A conditional PC write always comes with a subtract.
- A load's memory read is always followed by its write-back.

Only the bench's scenarios can show the rest:
- The exact step count for each opcode class.
- The full control word in each step.
- That an unknown opcode drops back to fetch with no writes.
- That an opcode changing outside decode has no effect.

To show these, the reference model runs a mixed instruction stream and drives a random opcode on every cycle that is not a decode edge.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LOAD, ST_LOADWB,
    ST_STORE, ST_ALUEX, ST_ALUWB, ST_BRANCH, ST_JUMP
  } step_e;

  typedef enum logic [2:0] {
    CL_LOAD, CL_STORE, CL_ALU, CL_BRANCH, CL_JUMP, CL_NONE
  } iclass_e;

  localparam logic [1:0] SRCB_REG   = 2'd0;
  localparam logic [1:0] SRCB_FOUR  = 2'd1;
  localparam logic [1:0] SRCB_OFS   = 2'd2;
  localparam logic [1:0] SRCB_OFSX4 = 2'd3;

  localparam logic [1:0] AOP_ADD  = 2'd0;
  localparam logic [1:0] AOP_SUB  = 2'd1;
  localparam logic [1:0] AOP_FUNC = 2'd2;

  localparam logic [1:0] PCS_ALU  = 2'd0;
  localparam logic [1:0] PCS_OUT  = 2'd1;
  localparam logic [1:0] PCS_JMP  = 2'd2;

  localparam logic [2:0] PH_FETCH = 3'd0;
  localparam logic [2:0] PH_DEC   = 3'd1;
  localparam logic [2:0] PH_EXE   = 3'd2;
  localparam logic [2:0] PH_MEM   = 3'd3;
  localparam logic [2:0] PH_WB    = 3'd4;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       iord;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       mem_to_reg;
    logic       reg_dst;
    logic       reg_wr;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic [2:0] phase;
  } ctrl_t;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_ctrl_pkg::*;
#(
  parameter int              OPW       = 6,
  parameter logic [OPW-1:0]  OP_LOAD   = 6'b100011,
  parameter logic [OPW-1:0]  OP_STORE  = 6'b101011,
  parameter logic [OPW-1:0]  OP_ALU    = 6'b000000,
  parameter logic [OPW-1:0]  OP_BRANCH = 6'b000100,
  parameter logic [OPW-1:0]  OP_JUMP   = 6'b000010
) (
  input  logic [OPW-1:0] opcode,
  output iclass_e        cls
);
  always_comb begin
    if      (opcode == OP_LOAD)   cls = CL_LOAD;
    else if (opcode == OP_STORE)  cls = CL_STORE;
    else if (opcode == OP_ALU)    cls = CL_ALU;
    else if (opcode == OP_BRANCH) cls = CL_BRANCH;
    else if (opcode == OP_JUMP)   cls = CL_JUMP;
    else                          cls = CL_NONE;
  end
endmodule

// File: rtl/mc_step_seq.sv
module mc_step_seq
  import mc_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  iclass_e cls_in,
  output step_e   state_q,
  output step_e   state_d
);
  iclass_e cls_q;

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (cls_in)
          CL_LOAD, CL_STORE: state_d = ST_ADDR;
          CL_ALU:            state_d = ST_ALUEX;
          CL_BRANCH:         state_d = ST_BRANCH;
          CL_JUMP:           state_d = ST_JUMP;
          default:           state_d = ST_FETCH;
        endcase
      end
      ST_ADDR:   state_d = (cls_q == CL_LOAD) ? ST_LOAD : ST_STORE;
      ST_LOAD:   state_d = ST_LOADWB;
      ST_ALUEX:  state_d = ST_ALUWB;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      cls_q   <= CL_NONE;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) cls_q <= cls_in;
    end
  end

  // R4
  load_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_LOAD |=> state_q == ST_LOADWB);

  // R3
  fetch_to_dec_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FETCH |=> state_q == ST_DECODE);
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  step_e st,
  output ctrl_t c
);
  always_comb begin
    c = '0;
    unique case (st)
      ST_FETCH: begin
        c.mem_rd    = 1'b1;
        c.ir_wr     = 1'b1;
        c.pc_wr     = 1'b1;
        c.alu_src_b = SRCB_FOUR;
        c.alu_op    = AOP_ADD;
        c.pc_src    = PCS_ALU;
        c.phase     = PH_FETCH;
      end
      ST_DECODE: begin
        c.alu_src_b = SRCB_OFSX4;
        c.phase     = PH_DEC;
      end
      ST_ADDR: begin
        c.alu_src_a = 1'b1;
        c.alu_src_b = SRCB_OFS;
        c.phase     = PH_EXE;
      end
      ST_LOAD: begin
        c.mem_rd = 1'b1;
        c.iord   = 1'b1;
        c.phase  = PH_MEM;
      end
      ST_LOADWB: begin
        c.reg_wr     = 1'b1;
        c.mem_to_reg = 1'b1;
        c.phase      = PH_WB;
      end
      ST_STORE: begin
        c.mem_wr = 1'b1;
        c.iord   = 1'b1;
        c.phase  = PH_MEM;
      end
      ST_ALUEX: begin
        c.alu_src_a = 1'b1;
        c.alu_src_b = SRCB_REG;
        c.alu_op    = AOP_FUNC;
        c.phase     = PH_EXE;
      end
      ST_ALUWB: begin
        c.reg_wr  = 1'b1;
        c.reg_dst = 1'b1;
        c.phase   = PH_MEM;
      end
      ST_BRANCH: begin
        c.alu_src_a  = 1'b1;
        c.alu_op     = AOP_SUB;
        c.pc_wr_cond = 1'b1;
        c.pc_src     = PCS_OUT;
        c.phase      = PH_EXE;
      end
      ST_JUMP: begin
        c.pc_wr  = 1'b1;
        c.pc_src = PCS_JMP;
        c.phase  = PH_EXE;
      end
      default: c = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int             OPW       = 6,
  parameter logic [OPW-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OPW-1:0] OP_STORE  = 6'b101011,
  parameter logic [OPW-1:0] OP_ALU    = 6'b000000,
  parameter logic [OPW-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OPW-1:0] OP_JUMP   = 6'b000010
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic           iord,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_wr,
  output logic           mem_to_reg,
  output logic           reg_dst,
  output logic           reg_wr,
  output logic           alu_src_a,
  output logic [1:0]     alu_src_b,
  output logic [1:0]     alu_op,
  output logic [1:0]     pc_src,
  output logic [2:0]     phase
);
  iclass_e cls;
  step_e   state_q, state_d;
  ctrl_t   ctrl_d, ctrl_q, ctrl_rst;

  mc_op_classify #(
    .OPW(OPW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_ALU(OP_ALU), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_cls (
    .opcode (opcode),
    .cls    (cls)
  );

  mc_step_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .cls_in  (cls),
    .state_q (state_q),
    .state_d (state_d)
  );

  mc_ctrl_decode u_dec_next (.st(state_d),  .c(ctrl_d));
  mc_ctrl_decode u_dec_rst  (.st(ST_FETCH), .c(ctrl_rst));

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= ctrl_rst;
    else     ctrl_q <= ctrl_d;
  end

  assign pc_wr      = ctrl_q.pc_wr;
  assign pc_wr_cond = ctrl_q.pc_wr_cond;
  assign iord       = ctrl_q.iord;
  assign mem_rd     = ctrl_q.mem_rd;
  assign mem_wr     = ctrl_q.mem_wr;
  assign ir_wr      = ctrl_q.ir_wr;
  assign mem_to_reg = ctrl_q.mem_to_reg;
  assign reg_dst    = ctrl_q.reg_dst;
  assign reg_wr     = ctrl_q.reg_wr;
  assign alu_src_a  = ctrl_q.alu_src_a;
  assign alu_src_b  = ctrl_q.alu_src_b;
  assign alu_op     = ctrl_q.alu_op;
  assign pc_src     = ctrl_q.pc_src;
  assign phase      = ctrl_q.phase;

  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R2
  ir_wr_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    ir_wr |-> phase == PH_FETCH);

  // R3
  dec_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH |=> phase == PH_DEC);

  // R6
  reg_wr_late_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> (phase == PH_MEM || phase == PH_WB));

  // R7
  cond_sub_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> alu_op == AOP_SUB);

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_WB);
endmodule

// File: tb/sim_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr;
  logic       mem_to_reg, reg_dst, reg_wr, alu_src_a;
  logic [1:0] alu_src_b, alu_op, pc_src;
  logic [2:0] phase;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .iord(iord),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .reg_wr(reg_wr),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
    .pc_src(pc_src), .phase(phase)
  );

  // instruction classes: 0 load, 1 store, 2 alu, 3 branch, 4 jump, 5 other
  function automatic int classify(logic [5:0] op);
    if (op == 6'b100011) return 0;
    if (op == 6'b101011) return 1;
    if (op == 6'b000000) return 2;
    if (op == 6'b000100) return 3;
    if (op == 6'b000010) return 4;
    return 5;
  endfunction

  // word: pc_wr pc_wr_cond iord mem_rd mem_wr ir_wr m2r rdst rwr srca srcb[2] op[2] pcs[2] phase[3]
  function automatic logic [18:0] pack(bit pw, bit pwc, bit io, bit mr, bit mw, bit iw,
                                       bit m2r, bit rd, bit rw, bit sa, int sb, int op,
                                       int ps, int ph);
    return {pw, pwc, io, mr, mw, iw, m2r, rd, rw, sa, 2'(sb), 2'(op), 2'(ps), 3'(ph)};
  endfunction

  // model: ph = step number, cls = class of the instruction in flight
  function automatic logic [18:0] expect_word(int ph, int cls);
    if (ph == 0) return pack(1,0,0,1,0,1,0,0,0,0,1,0,0,0);
    if (ph == 1) return pack(0,0,0,0,0,0,0,0,0,0,3,0,0,1);
    if (ph == 2) begin
      if (cls <= 1) return pack(0,0,0,0,0,0,0,0,0,1,2,0,0,2);
      if (cls == 2) return pack(0,0,0,0,0,0,0,0,0,1,0,2,0,2);
      if (cls == 3) return pack(0,1,0,0,0,0,0,0,0,1,0,1,1,2);
      return pack(1,0,0,0,0,0,0,0,0,0,0,0,2,2);
    end
    if (ph == 3) begin
      if (cls == 0) return pack(0,0,1,1,0,0,0,0,0,0,0,0,0,3);
      if (cls == 1) return pack(0,0,1,0,1,0,0,0,0,0,0,0,0,3);
      return pack(0,0,0,0,0,0,0,1,1,0,0,0,0,3);
    end
    return pack(0,0,0,0,0,0,1,0,1,0,0,0,0,4);
  endfunction

  function automatic int last_phase(int cls);
    if (cls == 0) return 4;
    if (cls == 1 || cls == 2) return 3;
    if (cls == 3 || cls == 4) return 2;
    return 1;
  endfunction

  function automatic string req_name(int ph, int cls);
    if (ph == 0) return "R2";
    if (cls == 5) return "R9";
    if (ph == 1) return "R3";
    case (cls)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [18:0] actual();
    return {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg, reg_dst,
            reg_wr, alu_src_a, alu_src_b, alu_op, pc_src, phase};
  endfunction

  task automatic compare(string req, logic [18:0] exp);
    checks++;
    if (actual() !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, actual(), exp);
    end
  endtask

  logic [5:0] prog [12] = '{6'b100011, 6'b000000, 6'b101011, 6'b000100,
                            6'b000010, 6'b111111, 6'b100011, 6'b100011,
                            6'b001000, 6'b000100, 6'b101011, 6'b000000};

  initial begin
    int ph;
    int cls;
    int idx;
    // R1: reset state, with a changing opcode that must not matter
    repeat (3) begin
      @(negedge clk);
      opcode = 6'($urandom);
      compare("R1", expect_word(0, 5));
    end
    opcode = 6'b000100;
    @(negedge clk);
    compare("R1", expect_word(0, 5));
    rst = 1'b0;
    ph = 0; cls = 5; idx = 0;
    for (int cyc = 0; cyc < 1500; cyc++) begin
      compare((cyc == 0) ? "R1" : req_name(ph, cls), expect_word(ph, cls));
      checks++;
      if (mem_rd && mem_wr) begin
        failures++;
        $display("FAIL R10 t=%0t actual=rd%0b_wr%0b expected=not both", $time, mem_rd, mem_wr);
      end
      if (ph == 1) begin
        // decode edge samples the opcode
        if (idx < 24) opcode = prog[idx % 12];
        else          opcode = 6'($urandom);
        idx++;
        cls = classify(opcode);
        ph = (cls == 5) ? 0 : 2;
      end else begin
        // R11: garbage opcode outside decode must be ignored
        opcode = 6'($urandom);
        if (ph == 0 || ph >= last_phase(cls)) ph = (ph == 0) ? 1 : 0;
        else ph = ph + 1;
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog t=%0t actual=running expected=finished", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule